// File: doc/BRIEF.md
# SHA-512 Message Schedule Helper

This unit computes four 64-bit message-schedule words for SHA-512 per operation and holds them in an output register. A single `op` bit picks one of two steps. The partial step adds the small sigma-0 of each neighbouring word to a word. The final step adds small sigma-1 terms. In the final step the upper two result lanes are built from the lower two lanes of the same result, so they form a serial chain.

A caller combines the two steps to extend a message block. It presents two packed 256-bit operands, each holding four 64-bit lanes with lane k at bits [64k+63:64k], and pulses `in_valid`. One cycle later the result appears on `result` and `out_valid` is high. Round constants, block loading and the compression rounds belong to other logic.

Top module: `msg_sched_unit`

## Requirements
- R1: A synchronous active-high `rst` forces `out_valid` low at the next clock edge, whatever `in_valid` is.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge, when reset was not asserted.
- R3: With `op` = 0 (partial step), let W0..W3 be lanes 0..3 of `opnd_a` and let W4 be lane 0 of `opnd_b`. Result lane i is W[i] + sig0(W[i+1]) for i = 0..3.
- R4: sig0(x) = rotr(x,1) ^ rotr(x,8) ^ (x >> 7), where >> is a logical shift that fills with zeros.
- R5: sig1(x) = rotr(x,19) ^ rotr(x,61) ^ (x >> 6), where >> is a logical shift.
- R6: With `op` = 1 (final step), result lane 0 is `opnd_a` lane 0 + sig1(`opnd_b` lane 2), and result lane 1 is `opnd_a` lane 1 + sig1(`opnd_b` lane 3).
- R7: With `op` = 1, result lane 2 is `opnd_a` lane 2 + sig1(result lane 0), and result lane 3 is `opnd_a` lane 3 + sig1(result lane 1).
- R8: Every addition is modulo 2^64. The carry out of a lane is dropped and never reaches the next lane.
- R9: With `op` = 0, bits [255:64] of `opnd_b` have no effect on `result`.
- R10: `result` loads only on a cycle where `in_valid` is high. Otherwise it keeps its value, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Loads the result register with the selected step |
| op | input | 1 | 0 selects the partial step, 1 selects the final step |
| opnd_a | input | 256 | Operand A, four 64-bit lanes |
| opnd_b | input | 256 | Operand B, four 64-bit lanes |
| out_valid | output | 1 | High one cycle after a load |
| result | output | 256 | Registered four-lane result |

## Verification
Walking-one sweeps over every bit of both operands, run in both steps, isolate the rotate and shift amounts. A wrong rotation, or a rotate where a shift belongs, moves a single bit to the wrong position. All-ones lanes force a carry out of every adder, so a lane that leaks its carry into its neighbour gives a visibly wrong lane. One group of final-step vectors makes the chained lanes differ from what they would be if they were fed from operand B. Another group changes only the upper bits of B in the partial step, which catches a design that decodes the wrong lane of B. Hold checks change the operands while `in_valid` is low, to catch a register that loads without a valid strobe.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  localparam int LANE_W = 64;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANE_W * LANES;
  localparam int CHAIN  = 2;  // distance between a final-step lane and the lane it depends on

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic {
    OP_PARTIAL = 1'b0,
    OP_FINAL   = 1'b1
  } sched_op_e;

  function automatic lane_t rotr(input lane_t x, input int n);
    return (x >> n) | (x << (LANE_W - n));
  endfunction

  function automatic lane_t small_sig0(input lane_t x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic lane_t small_sig1(input lane_t x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction
endpackage

// File: rtl/sched_partial_step.sv
module sched_partial_step
  import msg_sched_pkg::*;
(
  input  logic [VEC_W-1:0] a_vec,
  input  logic [LANE_W-1:0] b_low,
  output logic [VEC_W-1:0] res_vec
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_t w_self;
    lane_t w_next;
    assign w_self = a_vec[i*LANE_W +: LANE_W];
    if (i == LANES - 1) begin : g_edge
      assign w_next = b_low;
    end else begin : g_inner
      assign w_next = a_vec[(i+1)*LANE_W +: LANE_W];
    end
    assign res_vec[i*LANE_W +: LANE_W] = w_self + small_sig0(w_next);
  end
endmodule

// File: rtl/sched_final_step.sv
module sched_final_step
  import msg_sched_pkg::*;
(
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] b_vec,
  output logic [VEC_W-1:0] res_vec
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lane_t feed;
    if (k < CHAIN) begin : g_head
      assign feed = b_vec[(k+LANES-CHAIN)*LANE_W +: LANE_W];
    end else begin : g_tail
      assign feed = res_vec[(k-CHAIN)*LANE_W +: LANE_W];
    end
    assign res_vec[k*LANE_W +: LANE_W] = a_vec[k*LANE_W +: LANE_W] + small_sig1(feed);
  end
endmodule

// File: rtl/msg_sched_unit.sv
module msg_sched_unit
  import msg_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op,
  input  logic [255:0]     opnd_a,
  input  logic [255:0]     opnd_b,
  output logic             out_valid,
  output logic [255:0]     result
);
  logic [VEC_W-1:0] partial_res;
  logic [VEC_W-1:0] final_res;
  logic [VEC_W-1:0] next_res;
  logic             load_en;
  sched_op_e        op_sel;

  assign op_sel  = sched_op_e'(op);
  assign load_en = in_valid;

  sched_partial_step u_partial (
    .a_vec  (opnd_a),
    .b_low  (opnd_b[LANE_W-1:0]),
    .res_vec(partial_res)
  );

  sched_final_step u_final (
    .a_vec  (opnd_a),
    .b_vec  (opnd_b),
    .res_vec(final_res)
  );

  always_comb begin
    case (op_sel)
      OP_FINAL: next_res = final_res;
      default:  next_res = partial_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= load_en;
  end

  always_ff @(posedge clk) begin
    if (load_en) result <= next_res;
  end
endmodule

// File: rtl/msg_sched_unit_chk.sv
module msg_sched_unit_chk
  import msg_sched_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         op,
  input logic [255:0] opnd_a,
  input logic [255:0] opnd_b,
  input logic         out_valid,
  input logic [255:0] result
);
  p_reset_r1: assert property (@(posedge clk) rst |=> !out_valid);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_partial_lane0_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op) |=> result[63:0] == $past(opnd_a[63:0]) + small_sig0($past(opnd_a[127:64])));

  p_partial_edge_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op) |=> result[255:192] == $past(opnd_a[255:192]) + small_sig0($past(opnd_b[63:0])));

  p_final_head_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op) |=> result[63:0] == $past(opnd_a[63:0]) + small_sig1($past(opnd_b[191:128])));

  p_final_chain_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op) |=> result[191:128] == $past(opnd_a[191:128]) + small_sig1(result[63:0]));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
endmodule

bind msg_sched_unit msg_sched_unit_chk u_chk (.*);

// File: tb/msg_sched_unit_bench.sv
`timescale 1ns/1ps
module msg_sched_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         op;
  logic [255:0] opnd_a;
  logic [255:0] opnd_b;
  logic         out_valid;
  logic [255:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  msg_sched_unit u_msg_sched_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] m_s0(input logic [63:0] x);
    return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ {7'b0, x[63:7]};
  endfunction

  function automatic logic [63:0] m_s1(input logic [63:0] x);
    return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ {6'b0, x[63:6]};
  endfunction

  function automatic logic [255:0] model(input logic o, input logic [255:0] a, input logic [255:0] b);
    logic [63:0] w16, w17;
    if (!o)
      return {a[255:192] + m_s0(b[63:0]),   a[191:128] + m_s0(a[255:192]),
              a[127:64]  + m_s0(a[191:128]), a[63:0]    + m_s0(a[127:64])};
    w16 = a[63:0]   + m_s1(b[191:128]);
    w17 = a[127:64] + m_s1(b[255:192]);
    return {a[255:192] + m_s1(w17), a[191:128] + m_s1(w16), w17, w16};
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic o, input logic [255:0] a, input logic [255:0] b, input string tag);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid R2"}, {255'b0, out_valid}, 256'd1);
    check(tag, result, model(o, a, b));
  endtask

  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
  function automatic logic [63:0] step(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction
  task automatic rnd256(output logic [255:0] v);
    for (int i = 0; i < 4; i++) begin
      lfsr = step(step(step(lfsr)));
      v[i*64 +: 64] = lfsr ^ {lfsr[31:0], lfsr[63:32]};
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] ra, rb, held;
    rst = 1'b1; in_valid = 1'b1; op = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R1 out_valid under reset", {255'b0, out_valid}, 256'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle out_valid", {255'b0, out_valid}, 256'd0);

    // R4, R5: isolated sigma functions through zero A lanes
    apply(1'b0, '0, {192'b0, 64'h8000_0000_0000_0001}, "R4 sig0 lane3");
    check("R4 sig0 value", {192'b0, result[255:192]}, {192'b0, m_s0(64'h8000_0000_0000_0001)});
    apply(1'b1, '0, {64'b0, 64'h0000_0000_0008_0001, 128'b0}, "R5 sig1 lane0");
    check("R5 sig1 value", {192'b0, result[63:0]}, {192'b0, m_s1(64'h0000_0000_0008_0001)});

    // R8: carry wrap in every lane
    apply(1'b0, {256{1'b1}}, {256{1'b1}}, "R8 carry partial");
    apply(1'b1, {256{1'b1}}, {256{1'b1}}, "R8 carry final");

    // R3, R6, R7: walking one over every bit of A and of B in both steps
    for (int p = 0; p < 256; p++) begin
      apply(1'b0, 256'd1 << p, 256'h5, "R3 walk A");
      apply(1'b0, 256'h3, 256'd1 << p, "R3 walk B");
      apply(1'b1, 256'd1 << p, 256'h0, "R6 R7 walk A");
      apply(1'b1, 256'h7, 256'd1 << p, "R6 R7 walk B");
    end

    // R6, R7: random final steps (chained lanes differ from an unchained result)
    for (int n = 0; n < 64; n++) begin
      rnd256(ra); rnd256(rb);
      apply(1'b1, ra, rb, "R7 random final");
      rnd256(ra); rnd256(rb);
      apply(1'b0, ra, rb, "R3 random partial");
    end

    // R9: upper B bits ignored in partial step
    for (int n = 0; n < 16; n++) begin
      rnd256(ra); rnd256(rb);
      apply(1'b0, ra, rb, "R9 base");
      held = result;
      apply(1'b0, ra, {~rb[255:64], rb[63:0]}, "R9 flipped");
      check("R9 upper B ignored", result, held);
    end

    // R10: hold while idle
    rnd256(ra); rnd256(rb);
    apply(1'b1, ra, rb, "R10 load");
    held = result;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      rnd256(opnd_a); rnd256(opnd_b); op = ~op;
      @(posedge clk); #1;
      check("R10 hold", result, held);
      check("R2 no valid", {255'b0, out_valid}, 256'd0);
    end

    // R1: reset overrides in_valid
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1 reset beats valid", {255'b0, out_valid}, 256'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule